// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides, once per clock, whether a pending exception or hardware interrupt is taken by a 32-bit CPU core. When one is taken, it saves the architectural state and picks the handler address. It looks at the status register it holds, the block bit, the sleep and delay-slot flags, and the answer of an external interrupt controller for the current mask level. It then either does nothing, enters a handler, or raises a reset request in place of an exception that cannot be taken.

On entry it copies the status register, the program counter and stack register R15 into their shadow registers, records the cause code, and sets the privileged, bank and block bits. It drives the new program counter and pulses an entry strobe. The core loads the new program counter on that strobe and clears its own sleep and delay-slot flags on the two clear pulses. The core can also write the status register directly through a load port. The controller, instruction decode and the return path are outside the block.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception and an interrupt are both pending in the same cycle, only the exception is entered. EXPEVT takes the code and INTEVT keeps its value.
- R2: If SR bit 28 (block) is 1 and an exception with a code other than 0x1E0 is pending, reset_req_o pulses for one cycle and nothing else changes. Code 0x1E0 is entered normally, even with the block bit set.
- R3: With the block bit set, an interrupt alone is ignored unless sleep_i is 1. Every accepted entry pulses sleep_clr_o for one cycle.
- R4: An interrupt is accepted only when irq_vec_valid_i is 1. The controller is given imask_o = SR[7:4]. An accepted interrupt writes irq_vec_i into INTEVT and sets the new PC to VBR+0x600.
- R5: On entry, SSR takes the old SR, SPC takes the PC and SGR takes R15.
- R6: On entry, SR bits 30 (privileged), 29 (bank) and 28 (block) become 1. The other bits keep their values, except as stated in R10.
- R7: If delay_i is 1 on entry, SPC is the PC minus 2 and dslot_clr_o pulses.
- R8: Exception codes 0x040 and 0x060 go to VBR+0x400. Every other code except those of R10 goes to VBR+0x100. The code is written to EXPEVT.
- R9: Code 0x160 adds 2 to SPC. This is applied after the delay-slot rewind, so the two cancel out.
- R10: Codes 0x000, 0x020 and 0x140 clear SR bit 15 (FPU disable), force SR[7:4] to 0xF and set the new PC to 0xA0000000.
- R11: After reset, SR = 0x700000F0 (privileged, bank and block set, mask 0xF), the strobes are low and the other registers are zero.
- R12: An interrupt is never accepted while delay_i is 1.
- R13: taken_o is high for exactly the cycle in which the new PC and the saved registers first show the entry. It is never high together with reset_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | Exception pending |
| exc_code_i | input | 12 | Exception cause code |
| irq_req_i | input | 1 | Hardware interrupt request |
| irq_vec_valid_i | input | 1 | Controller has an unmasked vector for imask_o |
| irq_vec_i | input | 12 | Interrupt vector code from the controller |
| delay_i | input | 1 | Core is in a delay slot |
| sleep_i | input | 1 | Core is sleeping |
| pc_i | input | 32 | Current program counter |
| r15_i | input | 32 | Current R15 |
| vbr_i | input | 32 | Vector base |
| sr_wr_i | input | 1 | Load SR from sr_wr_data_i (an entry takes precedence) |
| sr_wr_data_i | input | 32 | SR load value |
| imask_o | output | 4 | Current mask level SR[7:4] |
| sr_o | output | 32 | Status register |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved PC |
| sgr_o | output | 32 | Saved R15 |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt code |
| new_pc_o | output | 32 | Handler address |
| taken_o | output | 1 | Entry strobe |
| reset_req_o | output | 1 | Reset request |
| sleep_clr_o | output | 1 | Clear the core sleep flag |
| dslot_clr_o | output | 1 | Clear the core delay-slot flag |

## Verification
The bench targets these corner cases:
- An exception and an interrupt arriving together. A design that let the interrupt win would change INTEVT and jump to VBR+0x600.
- The block bit with code 0x1E0 versus other codes. A design with the wrong test would either enter a handler instead of requesting reset, or request reset for the one code that must pass.
- A trap in a delay slot. There the rewind and the trap adjust must cancel, and getting either one wrong shows up as an SPC off by 2.
- A sleeping core with the block bit set, an interrupt with no valid vector, an interrupt during a delay slot, and the three reset-class codes. A design that gets any of these wrong shows up as a wrong handler address or a stray entry strobe.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XW = 32;
  localparam int CW = 12;
  localparam int SR_MD = 30;
  localparam int SR_RB = 29;
  localparam int SR_BL = 28;
  localparam int SR_FD = 15;
  localparam int IM_LO = 4;
  localparam int IM_W  = 4;

  typedef enum logic [1:0] {ACT_IDLE, ACT_EXC, ACT_IRQ, ACT_RST} act_e;

  // Saved PC: delay-slot rewind first, then the trap adjust.
  function automatic logic [XW-1:0] save_pc(logic [XW-1:0] pc, logic dly, logic trap);
    logic [XW-1:0] r;
    r = pc;
    if (dly)  r = r - XW'(2);
    if (trap) r = r + XW'(2);
    return r;
  endfunction

  // SR value after entry.
  function automatic logic [XW-1:0] enter_sr(logic [XW-1:0] sr, logic rst_class);
    logic [XW-1:0] r;
    r = sr;
    r[SR_MD] = 1'b1;
    r[SR_RB] = 1'b1;
    r[SR_BL] = 1'b1;
    if (rst_class) begin
      r[SR_FD] = 1'b0;
      r[IM_LO +: IM_W] = '1;
    end
    return r;
  endfunction
endpackage

// File: rtl/exc_decide.sv
module exc_decide
  import exc_pkg::*;
#(
  parameter logic [XW-1:0] RST_VEC  = 32'hA000_0000,
  parameter logic [XW-1:0] OFS_GEN  = 32'h0000_0100,
  parameter logic [XW-1:0] OFS_TLB  = 32'h0000_0400,
  parameter logic [XW-1:0] OFS_IRQ  = 32'h0000_0600,
  parameter logic [CW-1:0] CODE_PASS = 12'h1E0
) (
  input  logic          exc_valid,
  input  logic [CW-1:0] exc_code,
  input  logic          irq_req,
  input  logic          vec_valid,
  input  logic          in_delay,
  input  logic          in_sleep,
  input  logic [XW-1:0] pc,
  input  logic [XW-1:0] vbr,
  input  logic [XW-1:0] sr,
  output act_e          act,
  output logic [XW-1:0] sr_next,
  output logic [XW-1:0] spc_next,
  output logic [XW-1:0] pc_next
);
  logic bl, rst_class, tlb_class, trap;

  assign bl        = sr[SR_BL];
  assign rst_class = (exc_code == 12'h000) || (exc_code == 12'h020) || (exc_code == 12'h140);
  assign tlb_class = (exc_code == 12'h040) || (exc_code == 12'h060);
  assign trap      = (exc_code == 12'h160);

  always_comb begin
    act = ACT_IDLE;
    if (exc_valid) begin
      act = (bl && exc_code != CODE_PASS) ? ACT_RST : ACT_EXC;
    end else if (irq_req && !in_delay && (!bl || in_sleep) && vec_valid) begin
      act = ACT_IRQ;
    end
  end

  always_comb begin
    sr_next  = enter_sr(sr, act == ACT_EXC && rst_class);
    spc_next = save_pc(pc, in_delay, act == ACT_EXC && trap);
    if (act == ACT_IRQ)     pc_next = vbr + OFS_IRQ;
    else if (rst_class)     pc_next = RST_VEC;
    else if (tlb_class)     pc_next = vbr + OFS_TLB;
    else                    pc_next = vbr + OFS_GEN;
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter logic [XW-1:0] SR_RESET = 32'h7000_00F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  act_e          act,
  input  logic [XW-1:0] sr_next,
  input  logic [XW-1:0] spc_next,
  input  logic [XW-1:0] pc_next,
  input  logic [XW-1:0] r15,
  input  logic [CW-1:0] exc_code,
  input  logic [CW-1:0] irq_vec,
  input  logic          in_delay,
  input  logic          sr_wr,
  input  logic [XW-1:0] sr_wr_data,
  output logic [XW-1:0] sr_q,
  output logic [XW-1:0] ssr_q,
  output logic [XW-1:0] spc_q,
  output logic [XW-1:0] sgr_q,
  output logic [CW-1:0] expevt_q,
  output logic [CW-1:0] intevt_q,
  output logic [XW-1:0] pc_q,
  output logic          taken_q,
  output logic          rreq_q,
  output logic          sclr_q,
  output logic          dclr_q
);
  logic take;
  assign take = (act == ACT_EXC) || (act == ACT_IRQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= SR_RESET;
      ssr_q <= '0; spc_q <= '0; sgr_q <= '0; pc_q <= '0;
      expevt_q <= '0; intevt_q <= '0;
      taken_q <= 1'b0; rreq_q <= 1'b0; sclr_q <= 1'b0; dclr_q <= 1'b0;
    end else begin
      taken_q <= take;
      rreq_q  <= (act == ACT_RST);
      sclr_q  <= take;
      dclr_q  <= take && in_delay;
      if (take) begin
        ssr_q <= sr_q;
        spc_q <= spc_next;
        sgr_q <= r15;
        sr_q  <= sr_next;
        pc_q  <= pc_next;
        if (act == ACT_EXC) expevt_q <= exc_code;
        else                intevt_q <= irq_vec;
      end else if (sr_wr) begin
        sr_q <= sr_wr_data;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter logic [XW-1:0] RST_VEC   = 32'hA000_0000,
  parameter logic [XW-1:0] OFS_GEN   = 32'h0000_0100,
  parameter logic [XW-1:0] OFS_TLB   = 32'h0000_0400,
  parameter logic [XW-1:0] OFS_IRQ   = 32'h0000_0600,
  parameter logic [CW-1:0] CODE_PASS = 12'h1E0,
  parameter logic [XW-1:0] SR_RESET  = 32'h7000_00F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_valid_i,
  input  logic [CW-1:0] exc_code_i,
  input  logic          irq_req_i,
  input  logic          irq_vec_valid_i,
  input  logic [CW-1:0] irq_vec_i,
  input  logic          delay_i,
  input  logic          sleep_i,
  input  logic [XW-1:0] pc_i,
  input  logic [XW-1:0] r15_i,
  input  logic [XW-1:0] vbr_i,
  input  logic          sr_wr_i,
  input  logic [XW-1:0] sr_wr_data_i,
  output logic [IM_W-1:0] imask_o,
  output logic [XW-1:0] sr_o,
  output logic [XW-1:0] ssr_o,
  output logic [XW-1:0] spc_o,
  output logic [XW-1:0] sgr_o,
  output logic [CW-1:0] expevt_o,
  output logic [CW-1:0] intevt_o,
  output logic [XW-1:0] new_pc_o,
  output logic          taken_o,
  output logic          reset_req_o,
  output logic          sleep_clr_o,
  output logic          dslot_clr_o
);
  act_e          act;
  logic [XW-1:0] sr_next, spc_next, pc_next;
  logic          exc_take_w, irq_take_w, rst_take_w;

  assign exc_take_w = (act == ACT_EXC);
  assign irq_take_w = (act == ACT_IRQ);
  assign rst_take_w = (act == ACT_RST);
  assign imask_o    = sr_o[IM_LO +: IM_W];

  exc_decide #(
    .RST_VEC(RST_VEC), .OFS_GEN(OFS_GEN), .OFS_TLB(OFS_TLB),
    .OFS_IRQ(OFS_IRQ), .CODE_PASS(CODE_PASS)
  ) u_decide (
    .exc_valid(exc_valid_i), .exc_code(exc_code_i), .irq_req(irq_req_i),
    .vec_valid(irq_vec_valid_i), .in_delay(delay_i), .in_sleep(sleep_i),
    .pc(pc_i), .vbr(vbr_i), .sr(sr_o),
    .act(act), .sr_next(sr_next), .spc_next(spc_next), .pc_next(pc_next)
  );

  exc_regs #(.SR_RESET(SR_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .act(act), .sr_next(sr_next),
    .spc_next(spc_next), .pc_next(pc_next), .r15(r15_i),
    .exc_code(exc_code_i), .irq_vec(irq_vec_i), .in_delay(delay_i),
    .sr_wr(sr_wr_i), .sr_wr_data(sr_wr_data_i),
    .sr_q(sr_o), .ssr_q(ssr_o), .spc_q(spc_o), .sgr_q(sgr_o),
    .expevt_q(expevt_o), .intevt_q(intevt_o), .pc_q(new_pc_o),
    .taken_q(taken_o), .rreq_q(reset_req_o), .sclr_q(sleep_clr_o),
    .dclr_q(dslot_clr_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_valid_i,
  input logic [11:0] exc_code_i,
  input logic        irq_req_i,
  input logic        delay_i,
  input logic [31:0] r15_i,
  input logic [31:0] vbr_i,
  input logic [31:0] sr_o,
  input logic [31:0] ssr_o,
  input logic [31:0] sgr_o,
  input logic [11:0] expevt_o,
  input logic [11:0] intevt_o,
  input logic [31:0] new_pc_o,
  input logic        taken_o,
  input logic        reset_req_o,
  input logic        exc_take_w,
  input logic        irq_take_w,
  input logic        rst_take_w
);
  // R1: exception wins, INTEVT untouched
  a_r1_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_i && irq_req_i && exc_take_w |=> expevt_o == $past(exc_code_i) && $stable(intevt_o));

  // R2: blocked exception becomes a reset request only
  a_r2_block_reset: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_i && sr_o[28] && exc_code_i != 12'h1E0 |=> reset_req_o && !taken_o && $stable(sr_o));

  // R4: accepted interrupt goes to VBR+0x600
  a_r4_irq_target: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_w |=> new_pc_o == $past(vbr_i) + 32'h600);

  // R5: state save
  a_r5_save: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take_w || irq_take_w) |=> ssr_o == $past(sr_o) && sgr_o == $past(r15_i));

  // R6: bank bits set after entry
  a_r6_bits: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> sr_o[30:28] == 3'b111);

  // R12: no interrupt in a delay slot
  a_r12_delay_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_i && !exc_valid_i && delay_i |=> !taken_o);

  // R13: strobes exclusive, strobe follows a decision
  a_r13_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken_o && reset_req_o));
  a_r13_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_take_w |=> !taken_o);
endmodule

bind exc_entry_seq exc_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
  .irq_req_i(irq_req_i), .delay_i(delay_i), .r15_i(r15_i), .vbr_i(vbr_i),
  .sr_o(sr_o), .ssr_o(ssr_o), .sgr_o(sgr_o), .expevt_o(expevt_o),
  .intevt_o(intevt_o), .new_pc_o(new_pc_o), .taken_o(taken_o),
  .reset_req_o(reset_req_o), .exc_take_w(exc_take_w),
  .irq_take_w(irq_take_w), .rst_take_w(rst_take_w)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VBR = 32'h8C00_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_valid_i = 0, irq_req_i = 0, irq_vec_valid_i = 0, delay_i = 0, sleep_i = 0, sr_wr_i = 0;
  logic [11:0] exc_code_i = '0, irq_vec_i = '0;
  logic [31:0] pc_i = '0, r15_i = '0, vbr_i = VBR, sr_wr_data_i = '0;
  logic [3:0]  imask_o;
  logic [31:0] sr_o, ssr_o, spc_o, sgr_o, new_pc_o;
  logic [11:0] expevt_o, intevt_o;
  logic taken_o, reset_req_o, sleep_clr_o, dslot_clr_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq u_dut (.*);

  typedef struct {
    string req;
    logic tk, rr, sc, dc;
    logic [31:0] sr, ssr, spc, sgr, pc;
    logic [11:0] ee, ie;
  } exp_t;
  exp_t q[$];

  // model state
  logic [31:0] m_sr = 32'h7000_00F0, m_ssr = 0, m_spc = 0, m_sgr = 0, m_pc = 0;
  logic [11:0] m_ee = 0, m_ie = 0;

  task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, nm, act, exp);
    end
  endtask

  task automatic step(string req, logic ev, logic [11:0] code, logic irq, logic vv,
                      logic [11:0] vec, logic dly, logic slp, logic [31:0] pc,
                      logic [31:0] r15, logic srw, logic [31:0] srd);
    exp_t e;
    logic entered, is_exc, rq;
    @(negedge clk);
    exc_valid_i = ev; exc_code_i = code; irq_req_i = irq; irq_vec_valid_i = vv;
    irq_vec_i = vec; delay_i = dly; sleep_i = slp; pc_i = pc; r15_i = r15;
    sr_wr_i = srw; sr_wr_data_i = srd;
    rq = 0; is_exc = 0; entered = 0;
    if (ev) begin
      if (m_sr[28] && code != 12'h1E0) rq = 1;
      else begin is_exc = 1; entered = 1; end
    end else if (irq && vv && !dly && (slp || !m_sr[28])) entered = 1;
    if (entered) begin
      m_ssr = m_sr; m_sgr = r15;
      m_spc = dly ? pc - 2 : pc;
      m_sr = m_sr | 32'h7000_0000;
      if (is_exc) begin
        m_ee = code;
        case (code)
          12'h000, 12'h020, 12'h140: begin m_sr = (m_sr & ~32'h8000) | 32'hF0; m_pc = 32'hA000_0000; end
          12'h040, 12'h060: m_pc = VBR + 32'h400;
          12'h160: begin m_spc = m_spc + 2; m_pc = VBR + 32'h100; end
          default: m_pc = VBR + 32'h100;
        endcase
      end else begin
        m_ie = vec; m_pc = VBR + 32'h600;
      end
    end else if (srw) m_sr = srd;
    e.req = req; e.tk = entered; e.rr = rq; e.sc = entered; e.dc = entered && dly;
    e.sr = m_sr; e.ssr = m_ssr; e.spc = m_spc; e.sgr = m_sgr; e.pc = m_pc;
    e.ee = m_ee; e.ie = m_ie;
    @(posedge clk); #1;
    q.push_back(e);
  endtask

  task automatic set_sr(logic [31:0] v);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, v);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "taken", {31'b0, taken_o}, {31'b0, e.tk});
      chk(e.req, "reset_req", {31'b0, reset_req_o}, {31'b0, e.rr});
      chk(e.req, "sleep_clr", {31'b0, sleep_clr_o}, {31'b0, e.sc});
      chk(e.req, "dslot_clr", {31'b0, dslot_clr_o}, {31'b0, e.dc});
      chk(e.req, "sr", sr_o, e.sr);
      chk(e.req, "imask", {28'b0, imask_o}, {28'b0, e.sr[7:4]});
      chk(e.req, "ssr", ssr_o, e.ssr);
      chk(e.req, "spc", spc_o, e.spc);
      chk(e.req, "sgr", sgr_o, e.sgr);
      if (e.tk) chk(e.req, "new_pc", new_pc_o, e.pc);
      chk(e.req, "expevt", {20'b0, expevt_o}, {20'b0, e.ee});
      chk(e.req, "intevt", {20'b0, intevt_o}, {20'b0, e.ie});
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "sr", sr_o, 32'h7000_00F0);
    chk("R11", "taken", {31'b0, taken_o}, 32'h0);
    chk("R11", "reset_req", {31'b0, reset_req_o}, 32'h0);
    chk("R11", "spc", spc_o, 32'h0);

    // R2: block bit set from reset, general exception -> reset request
    step("R2", 1, 12'h0A0, 0, 0, 0, 0, 0, 32'h100, 32'h55, 0, 0);
    // R2: code 0x1E0 passes the block bit
    step("R2", 1, 12'h1E0, 0, 0, 0, 0, 0, 32'h200, 32'h66, 0, 0);
    // R3: blocked interrupt, awake -> ignored
    step("R3", 0, 0, 1, 1, 12'h320, 0, 0, 32'h300, 32'h77, 0, 0);
    // R3: blocked interrupt, asleep -> taken
    step("R3", 0, 0, 1, 1, 12'h320, 0, 1, 32'h304, 32'h78, 0, 0);

    // R5 R8: general exception with clear SR
    set_sr(32'h0);
    step("R5", 1, 12'h0A0, 0, 0, 0, 0, 0, 32'h1000, 32'hABCD, 0, 0);
    set_sr(32'h0);
    step("R8", 1, 12'h040, 0, 0, 0, 0, 0, 32'h1100, 32'h1, 0, 0);
    set_sr(32'h0);
    step("R8", 1, 12'h060, 0, 0, 0, 0, 0, 32'h1200, 32'h2, 0, 0);
    // R9 trap
    set_sr(32'h0);
    step("R9", 1, 12'h160, 0, 0, 0, 0, 0, 32'h1300, 32'h3, 0, 0);
    // R7 R9 trap in delay slot
    set_sr(32'h0);
    step("R7", 1, 12'h160, 0, 0, 0, 1, 0, 32'h1400, 32'h4, 0, 0);
    // R7 plain exception in delay slot
    set_sr(32'h0);
    step("R7", 1, 12'h180, 0, 0, 0, 1, 0, 32'h1500, 32'h5, 0, 0);
    // R10 reset-class codes
    set_sr(32'h0000_8020);
    step("R10", 1, 12'h020, 0, 0, 0, 0, 0, 32'h1600, 32'h6, 0, 0);
    set_sr(32'h0000_8000);
    step("R10", 1, 12'h140, 0, 0, 0, 0, 0, 32'h1700, 32'h7, 0, 0);
    set_sr(32'h0000_8000);
    step("R10", 1, 12'h000, 0, 0, 0, 0, 0, 32'h1800, 32'h8, 0, 0);
    // R4 interrupt with mask 3
    set_sr(32'h0000_0030);
    step("R4", 0, 0, 1, 1, 12'h240, 0, 0, 32'h1900, 32'h9, 0, 0);
    // R4 no valid vector
    set_sr(32'h0000_0030);
    step("R4", 0, 0, 1, 0, 12'h260, 0, 0, 32'h1A00, 32'hA, 0, 0);
    // R12 interrupt during delay slot
    step("R12", 0, 0, 1, 1, 12'h280, 1, 0, 32'h1B00, 32'hB, 0, 0);
    // R1 exception and interrupt together
    step("R1", 1, 12'h100, 1, 1, 12'h2A0, 0, 0, 32'h1C00, 32'hC, 0, 0);
    // R13 back-to-back entries each strobe
    set_sr(32'h0);
    step("R13", 0, 0, 1, 1, 12'h2C0, 0, 0, 32'h1D00, 32'hD, 0, 0);
    step("R13", 1, 12'h1E0, 0, 0, 0, 0, 0, 32'h1E00, 32'hE, 0, 0);
    step("R13", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule